// File: doc/BRIEF.md
# Per-Bit Sampler Offset Calibrator

This block finds the input-sampler offset trim for every data bit of one byte lane. It walks a 4-bit offset code upward from 1 to 15 and broadcasts the same code to every bit through a 32-bit offset word. At each code it raises a train strobe, waits for the analog front end to settle, then samples the per-bit feedback and drops the strobe again.

For every bit, two trackers are kept. One holds the lowest code at which the feedback read 0. The other holds the highest code at which the feedback read 1. A value of 0 in either tracker means that event was never seen. When the sweep ends, each bit's centre code is the halved sum of its two trackers. Two saturation rules then apply: a bit that never read 0 is forced to the top code, and a bit that never read 1 is forced to the bottom code. The centres are packed into a 32-bit result word.

An optional nine-bit mode also trains the lane's strobe input. Its centre is reported on a separate 4-bit port. Software or a lane scheduler pulses start, waits for the one-cycle done pulse, and then uses the packed word.

Top module: `samp_ofs_cal`

## Requirements
- R1: After reset, offset_word_o, result_o and extra_o are 0, and train_strobe_o, busy_o and done_o are low.
- R2: During a sweep the offset code takes the values 1, 2, …, 15, in ascending order, one value per step. In every step, all eight nibbles of offset_word_o carry that code, with bit n's nibble at bits 4n+3..4n.
- R3: In every step train_strobe_o is high for exactly SETTLE_CYC+1 consecutive cycles. Feedback is sampled in the last of these cycles. The strobe is then low for exactly one cycle before the next step begins.
- R4: For each trained bit, last_one is the highest code at which the feedback read 1, and first_zero is the lowest code at which it read 0. Either tracker is 0 if that event never occurred.
- R5: When both trackers are nonzero, the centre code is floor((first_zero + last_one)/2), clamped to 0..15. The sum is formed with one extra bit, so it does not overflow before the halving.
- R6: A bit whose first_zero is 0 gets centre 15. A bit whose last_one is 0 gets centre 0, and this second rule takes priority over the first.
- R7: result_o carries the centre of data bit n at bits 4n+3..4n.
- R8: When nine_bit_i is high at start, fb_i[8] is trained as a ninth bit, and its centre appears on extra_o. When nine_bit_i is low at start, fb_i[8] has no effect and extra_o is 0 at done.
- R9: done_o is high for exactly one cycle at the end of a sweep. result_o and extra_o hold their values from that point until the next sweep completes.
- R10: A start pulse while busy_o is high is ignored. The running sweep still performs exactly 15 steps and produces one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sweep when idle |
| nine_bit_i | input | 1 | Selects nine-bit mode (train the strobe bit); captured at start |
| fb_i | input | 9 | Per-bit sampler feedback; bit 8 is the strobe bit |
| offset_word_o | output | 32 | Broadcast offset code, one nibble per data bit |
| train_strobe_o | output | 1 | Train-mode strobe to the lane |
| busy_o | output | 1 | A sweep is in progress |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| result_o | output | 32 | Packed per-bit centre codes |
| extra_o | output | 4 | Centre code of the strobe bit in nine-bit mode |

## Verification
The first group of feedback patterns uses clean monotone thresholds that rotate across all sixteen positions on every bit. These separate the ordinary midpoint case from the two saturation cases, and they also reveal any swapping of nibble positions between bits. The second group uses pseudo-random, non-monotone patterns. Here first_zero and last_one lie far apart, in either order, which shows whether the trackers keep the first zero and the last one rather than some other crossing. The runs alternate between eight-bit and nine-bit modes with a random strobe-bit pattern, which exposes leakage of fb_i[8] in eight-bit mode. A mid-sweep start pulse checks that a running sweep is not restarted.

// File: rtl/samp_ofs_pkg.sv
package samp_ofs_pkg;

  localparam int CODE_W   = 4;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_SAMPLE  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_DONE    = 3'd4
  } cal_state_e;

endpackage

// File: rtl/samp_ofs_seq.sv
module samp_ofs_seq
  import samp_ofs_pkg::*;
#(
  parameter int SETTLE_CYC = 250
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  output code_t code_o,
  output logic  strobe_o,
  output logic  clear_o,
  output logic  sample_o,
  output logic  finish_o,
  output logic  done_o,
  output logic  busy_o
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam code_t CODE_TOP = code_t'(CODE_MAX);

  cal_state_e       state_q, state_d;
  code_t            code_q, code_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SETTLE;
          code_d  = code_t'(1);
          cnt_d   = '0;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == CNT_LAST) state_d = ST_SAMPLE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_SAMPLE: state_d = ST_RELEASE;
      ST_RELEASE: begin
        if (code_q == CODE_TOP) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_SETTLE;
          code_d  = code_q + 1'b1;
          cnt_d   = '0;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      cnt_q   <= cnt_d;
    end
  end

  assign code_o   = code_q;
  assign strobe_o = (state_q == ST_SETTLE) || (state_q == ST_SAMPLE);
  assign clear_o  = (state_q == ST_IDLE) && start_i;
  assign sample_o = (state_q == ST_SAMPLE);
  assign finish_o = (state_q == ST_RELEASE) && (code_q == CODE_TOP);
  assign done_o   = (state_q == ST_DONE);
  assign busy_o   = (state_q != ST_IDLE);

  // R2: while a sweep runs the code stays inside 1..15
  a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (code_q != '0));

  // R2: every new step after the first uses the next code
  a_r2_code_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_o) && code_q != code_t'(1)) |-> (code_q == $past(code_q) + 1'b1));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: a start while a step is running does not end the sweep
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

// File: rtl/samp_ofs_track.sv
module samp_ofs_track
  import samp_ofs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear_i,
  input  logic  en_i,
  input  logic  fb_i,
  input  code_t code_i,
  output code_t first_zero_o,
  output code_t last_one_o
);

  code_t fz_q, fz_d, lo_q, lo_d;
  logic  upd;

  always_comb begin
    fz_d = fz_q;
    lo_d = lo_q;
    upd  = clear_i || en_i;
    if (clear_i) begin
      fz_d = '0;
      lo_d = '0;
    end else if (en_i) begin
      if (fb_i)               lo_d = code_i;
      else if (fz_q == '0)    fz_d = code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fz_q <= '0;
      lo_q <= '0;
    end else if (upd) begin
      fz_q <= fz_d;
      lo_q <= lo_d;
    end
  end

  assign first_zero_o = fz_q;
  assign last_one_o   = lo_q;

  // R4: a sampled 1 records the current code as last one
  a_r4_last_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clear_i && fb_i) |=> (lo_q == $past(code_i)));

  // R4: once a first zero is recorded it never moves until cleared
  a_r4_first_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fz_q != '0 && !clear_i) |=> (fz_q == $past(fz_q)));

endmodule

// File: rtl/samp_ofs_centre.sv
module samp_ofs_centre
  import samp_ofs_pkg::*;
(
  input  code_t first_zero_i,
  input  code_t last_one_i,
  output code_t centre_o
);

  localparam int SUM_W = CODE_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] half;
  code_t            mid;

  always_comb begin
    sum  = {1'b0, first_zero_i} + {1'b0, last_one_i};
    half = sum >> 1;
    if (half > SUM_W'(CODE_MAX)) mid = code_t'(CODE_MAX);
    else                         mid = half[CODE_W-1:0];
    centre_o = mid;
    if (first_zero_i == '0) centre_o = code_t'(CODE_MAX);
    if (last_one_i == '0)   centre_o = '0;
  end

endmodule

// File: rtl/samp_ofs_cal.sv
module samp_ofs_cal
  import samp_ofs_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int SETTLE_CYC = 250
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        nine_bit_i,
  input  logic [DATA_BITS:0]          fb_i,
  output logic [DATA_BITS*CODE_W-1:0] offset_word_o,
  output logic                        train_strobe_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [DATA_BITS*CODE_W-1:0] result_o,
  output logic [CODE_W-1:0]           extra_o
);

  localparam int TRK_N  = DATA_BITS + 1;
  localparam int WORD_W = DATA_BITS * CODE_W;

  code_t code;
  logic  clear, sample, finish;
  logic  nine_q;

  code_t fz     [TRK_N];
  code_t lo     [TRK_N];
  code_t centre [TRK_N];

  logic [WORD_W-1:0] result_q, result_d;
  code_t             extra_q, extra_d;

  samp_ofs_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .code_o   (code),
    .strobe_o (train_strobe_o),
    .clear_o  (clear),
    .sample_o (sample),
    .finish_o (finish),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nine_q <= 1'b0;
    else if (clear) nine_q <= nine_bit_i;
  end

  for (genvar b = 0; b < TRK_N; b++) begin : g_bit
    logic en;
    if (b < DATA_BITS) begin : g_data
      assign en = sample;
      assign offset_word_o[b*CODE_W +: CODE_W] = code;
    end else begin : g_strobe
      assign en = sample && nine_q;
    end

    samp_ofs_track u_trk (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (clear),
      .en_i         (en),
      .fb_i         (fb_i[b]),
      .code_i       (code),
      .first_zero_o (fz[b]),
      .last_one_o   (lo[b])
    );

    samp_ofs_centre u_ctr (
      .first_zero_i (fz[b]),
      .last_one_i   (lo[b]),
      .centre_o     (centre[b])
    );

    // R6: a bit that never read 1 is pinned to the bottom code
    a_r6_low_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (lo[b] == '0) |-> (centre[b] == '0));
  end

  always_comb begin
    result_d = result_q;
    extra_d  = extra_q;
    if (finish) begin
      for (int b = 0; b < DATA_BITS; b++) result_d[b*CODE_W +: CODE_W] = centre[b];
      extra_d = nine_q ? centre[DATA_BITS] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      extra_q  <= '0;
    end else if (finish) begin
      result_q <= result_d;
      extra_q  <= extra_d;
    end
  end

  assign result_o = result_q;
  assign extra_o  = extra_q;

  // R8: eight-bit mode reports no strobe-bit centre
  a_r8_extra_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !nine_q) |-> (extra_o == '0));

  // R9: results stay put outside the completion cycle
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(finish) |-> $stable(result_o));

endmodule

// File: tb/sim_samp_ofs_cal.sv
module sim_samp_ofs_cal;

  localparam int SET = 12;

  logic        clk, rst_n, start, nine;
  logic [8:0]  fb;
  logic [31:0] word, result;
  logic        strobe, busy, done;
  logic [3:0]  extra;

  logic [15:0] pat [9];

  int n_chk, n_bad;
  int steps, hi_len, lo_len;
  logic prev_strobe, mon_en;

  samp_ofs_cal #(.DATA_BITS(8), .SETTLE_CYC(SET)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nine_bit_i(nine), .fb_i(fb),
    .offset_word_o(word), .train_strobe_o(strobe), .busy_o(busy), .done_o(done),
    .result_o(result), .extra_o(extra)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_comb begin
    for (int b = 0; b < 9; b++) begin
      fb[b] = pat[b][(b < 8) ? word[b*4 +: 4] : word[3:0]];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_centre(input logic [15:0] p);
    int fz = 0, lo = 0, c;
    for (int k = 1; k <= 15; k++) begin
      if (p[k]) lo = k;
      else if (fz == 0) fz = k;
    end
    c = (fz + lo) / 2;
    if (c > 15) c = 15;
    if (fz == 0) c = 15;
    if (lo == 0) c = 0;
    return c;
  endfunction

  // step monitor: R2 code order and replication, R3 strobe timing
  always @(negedge clk) begin
    if (mon_en) begin
      if (strobe && !prev_strobe) begin
        steps++;
        chk(word == {8{word[3:0]}}, "R2 nibble replication", word, {8{word[3:0]}});
        chk(int'(word[3:0]) == steps, "R2 code order", word[3:0], steps);
        if (steps > 1) chk(lo_len == 1, "R3 strobe low gap", lo_len, 1);
        hi_len = 1;
      end else if (strobe) begin
        hi_len++;
      end
      if (!strobe && prev_strobe) begin
        chk(hi_len == SET + 1, "R3 strobe high length", hi_len, SET + 1);
        lo_len = 1;
      end else if (!strobe) begin
        lo_len++;
      end
    end
    prev_strobe = strobe;
  end

  task automatic run(input bit mode, input bit poke);
    int wait_cyc;
    int ev;
    logic [31:0] held;
    steps = 0; hi_len = 0; lo_len = 0; mon_en = 1'b1;
    @(negedge clk); start = 1'b1; nine = mode;
    @(negedge clk); start = 1'b0; nine = ~mode;
    wait_cyc = 0;
    while (!done && wait_cyc < 2000) begin
      if (poke && wait_cyc == 40) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      wait_cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done reached", done, 1);
    chk(steps == 15, poke ? "R10 steps with mid start" : "R2 step count", steps, 15);
    for (int b = 0; b < 8; b++) begin
      ev = exp_centre(pat[b]);
      chk(int'(result[b*4 +: 4]) == ev,
          (ev == 0 || ev == 15) ? "R6 saturated centre R7" : "R4 R5 centre R7",
          result[b*4 +: 4], ev);
    end
    ev = mode ? exp_centre(pat[8]) : 0;
    chk(int'(extra) == ev, "R8 strobe-bit centre", extra, ev);
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(result == held, "R9 result held", result, held);
    chk(busy == 1'b0, "R10 idle after sweep", busy, 0);
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int t;
    n_chk = 0; n_bad = 0; mon_en = 1'b0; prev_strobe = 1'b0;
    start = 1'b0; nine = 1'b0; rst_n = 1'b0;
    for (int b = 0; b < 9; b++) pat[b] = '0;
    repeat (3) @(negedge clk);
    chk(word == 0 && result == 0 && extra == 0, "R1 reset words", result, 0);
    chk(!strobe && !busy && !done, "R1 reset controls", {strobe, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // monotone thresholds: bit reads 1 below threshold t (1..16)
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 9; b++) begin
        t = ((k + b) % 16) + 1;
        pat[b] = 16'(((32'd1 << t) - 1) & 32'hFFFE);
      end
      run(k[0], 1'b0);
    end

    // non-monotone pseudo-random patterns
    lfsr = 16'hACE1;
    for (int r = 0; r < 10; r++) begin
      for (int b = 0; b < 9; b++) begin
        for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pat[b] = lfsr;
      end
      run(r[0], r == 3 || r == 6);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule